// File: doc/BRIEF.md
# Eviction-Marked Prefetch Trigger

This block sits beside a fetch-target predictor and an instruction cache. It keeps one mark bit for every predictor entry. When the cache throws out a block, the cache reports the predictor index linked to that block, and the block sets that entry's mark. Later the predictor may produce that entry again. At that moment the block reads the mark, and if the mark is set it queues a prefetch for the predicted block address. It does not wait for a spare cache port, because the mark already says the block is gone from the cache. The predictor covers more blocks than the cache can hold, so these marks stay useful long after the eviction.

Requests leave through a small FIFO that uses a valid/ready handshake. A mark stays set until its request is accepted downstream, so a prefetch dropped because the queue is full can be triggered again by a later prediction. A companion probe filter can run beside this block to catch misses that the marks do not cover.

Top module: `evict_prefetch_trigger`

## Requirements
- R1: After a synchronous active-high reset, every mark bit is zero, the FIFO is empty and `pf_valid` is low.
- R2: An eviction sets the mark of `evict_idx`. An eviction alone never produces a request.
- R3: A prediction is taken when the mark of its index is set, the FIFO holds fewer than 4 requests, and no held request carries the same index. A taken prediction presents `pred_addr` on `pf_addr` with `pf_valid` high in the next cycle, or queues it behind older requests.
- R4: A prediction of an index whose mark is clear produces no request.
- R5: An eviction and a prediction of the same index in one cycle are handled as follows. The prediction sees the mark's old, clear value and produces no request. The mark is set afterwards, so the next prediction of that index triggers.
- R6: A mark is cleared in the cycle its request is accepted (`pf_valid` and `pf_ready` both high). After that, a prediction of the index produces no request. An eviction of the same index in the accepting cycle takes priority, and the mark stays set.
- R7: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_addr` hold. Requests are delivered in the order they were taken.
- R8: The FIFO holds 4 requests. A prediction that would trigger while 4 requests are held is dropped and its mark stays set. The FIFO never holds more than 4 requests.
- R9: A prediction of an index that already has a request waiting in the FIFO adds no second request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | Cache reports an eviction this cycle |
| evict_idx | input | IDX_W | Predictor index linked to the evicted block |
| pred_valid | input | 1 | Predictor produced an entry this cycle |
| pred_idx | input | IDX_W | Index of the predicted entry |
| pred_addr | input | ADDR_W | Predicted block address |
| pf_valid | output | 1 | Prefetch request available |
| pf_addr | output | ADDR_W | Block address to prefetch |
| pf_ready | input | 1 | Downstream accepts the request |

## Verification
Some behaviours are checked by assertions on every cycle:
- a request holds while it is stalled;
- the FIFO neither overflows nor underflows;
- an eviction leaves its mark set;
- an accept clears the mark unless a same-cycle eviction of that index wins;
- the output stays quiet unless a marked index is predicted.

Other behaviours can only be shown by the bench's scenarios:
- the same-cycle read-old ordering between an eviction and a prediction;
- dropped predictions keeping their marks and triggering later;
- suppression of duplicates already waiting in the queue;
- the order in which requests are delivered.

The bench sweeps every index of a small 8-entry configuration to cover these.

// File: rtl/ept_pkg.sv
package ept_pkg;
  localparam int unsigned EPT_IDX_W_DEF  = 6;
  localparam int unsigned EPT_ADDR_W_DEF = 26;
  localparam int unsigned EPT_DEPTH_DEF  = 4;
endpackage

// File: rtl/ept_mark_array.sv
module ept_mark_array #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] marks;

  // set has priority over clear for the same entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_mark
    always_ff @(posedge clk) begin
      if (rst)
        marks[g] <= 1'b0;
      else if (set_en && (set_idx == IDX_W'(g)))
        marks[g] <= 1'b1;
      else if (clr_en && (clr_idx == IDX_W'(g)))
        marks[g] <= 1'b0;
    end
  end

  // read returns the value held before this cycle's updates
  assign rd_bit = marks[rd_idx];

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (marks == '0));

  assert_evict_sets_R2: assert property (@(posedge clk) disable iff (rst)
    set_en |=> marks[$past(set_idx)]);

  assert_accept_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && (set_idx == clr_idx))) |=> !marks[$past(clr_idx)]);
endmodule

// File: rtl/ept_req_fifo.sv
module ept_req_fifo #(
  parameter int unsigned DATA_W = 26,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic              pop,
  input  logic [TAG_W-1:0]  q_tag,
  output logic              q_hit,
  output logic              full,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DEPTH-1:0]  slot_vld;
  logic [DEPTH-1:0]  slot_match;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push) begin
      data_mem[wr_ptr] <= push_data;
      tag_mem[wr_ptr]  <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      slot_vld <= '0;
    end else begin
      if (push) begin
        wr_ptr           <= bump(wr_ptr);
        slot_vld[wr_ptr] <= 1'b1;
      end
      if (pop) begin
        rd_ptr           <= bump(rd_ptr);
        slot_vld[rd_ptr] <= 1'b0;
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cam
    assign slot_match[g] = slot_vld[g] && (tag_mem[g] == q_tag);
  end

  assign q_hit     = |slot_match;
  assign full      = (count == CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = data_mem[rd_ptr];
  assign out_tag   = tag_mem[rd_ptr];

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CNT_W'(DEPTH)));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));

  assert_slots_track_count_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_vld) == int'(count));
endmodule

// File: rtl/evict_prefetch_trigger.sv
module evict_prefetch_trigger
  import ept_pkg::*;
#(
  parameter int unsigned IDX_W      = EPT_IDX_W_DEF,
  parameter int unsigned ADDR_W     = EPT_ADDR_W_DEF,
  parameter int unsigned FIFO_DEPTH = EPT_DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evict_valid,
  input  logic [IDX_W-1:0]  evict_idx,
  input  logic              pred_valid,
  input  logic [IDX_W-1:0]  pred_idx,
  input  logic [ADDR_W-1:0] pred_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_ready
);
  logic             mark_rd;
  logic             pend_hit;
  logic             q_full;
  logic             fire;
  logic             accept;
  logic [IDX_W-1:0] head_idx;

  assign accept = pf_valid && pf_ready;
  // trigger only on a marked entry with room and no waiting duplicate
  assign fire   = pred_valid && mark_rd && !pend_hit && !q_full;

  ept_mark_array #(.IDX_W(IDX_W)) u_marks (
    .clk     (clk),
    .rst     (rst),
    .set_en  (evict_valid),
    .set_idx (evict_idx),
    .clr_en  (accept),
    .clr_idx (head_idx),
    .rd_idx  (pred_idx),
    .rd_bit  (mark_rd)
  );

  ept_req_fifo #(
    .DATA_W (ADDR_W),
    .TAG_W  (IDX_W),
    .DEPTH  (FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (fire),
    .push_data (pred_addr),
    .push_tag  (pred_idx),
    .pop       (accept),
    .q_tag     (pred_idx),
    .q_hit     (pend_hit),
    .full      (q_full),
    .out_valid (pf_valid),
    .out_data  (pf_addr),
    .out_tag   (head_idx)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !pf_valid);

  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  assert_quiet_without_mark_R4: assert property (@(posedge clk) disable iff (rst)
    (!pf_valid && !(pred_valid && mark_rd)) |=> !pf_valid);
endmodule

// File: tb/evict_prefetch_trigger_test.sv
module evict_prefetch_trigger_test;
  localparam int IW = 3;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          evict_valid = 1'b0;
  logic [IW-1:0] evict_idx = '0;
  logic          pred_valid = 1'b0;
  logic [IW-1:0] pred_idx = '0;
  logic [AW-1:0] pred_addr = '0;
  logic          pf_valid;
  logic [AW-1:0] pf_addr;
  logic          pf_ready = 1'b0;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  evict_prefetch_trigger #(.IDX_W(IW), .ADDR_W(AW), .FIFO_DEPTH(4)) uut (
    .clk(clk), .rst(rst),
    .evict_valid(evict_valid), .evict_idx(evict_idx),
    .pred_valid(pred_valid), .pred_idx(pred_idx), .pred_addr(pred_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
  );

  function automatic logic [AW-1:0] fa(input int i, input int s);
    return AW'((i * 37 + s * 11 + 5) & 8'hFF);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic predict(input int i, input int s);
    pred_valid = 1'b1; pred_idx = IW'(i); pred_addr = fa(i, s);
    tick();
    pred_valid = 1'b0;
  endtask

  task automatic evict(input int i);
    evict_valid = 1'b1; evict_idx = IW'(i);
    tick();
    evict_valid = 1'b0;
  endtask

  task automatic drain_one(input int i, input int s, input string req);
    chk(pf_valid == 1'b1, req, int'(pf_valid), 1);
    chk(pf_addr == fa(i, s), req, int'(pf_addr), int'(fa(i, s)));
    pf_ready = 1'b1;
    tick();
    pf_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    chk(pf_valid == 1'b0, "R1", int'(pf_valid), 0);

    // R4 sweep: no marks set, no prediction triggers
    for (int i = 0; i < 8; i++) begin
      predict(i, 0);
      chk(pf_valid == 1'b0, "R4", int'(pf_valid), 0);
    end

    // R2 mark every entry, evictions alone stay quiet
    for (int i = 0; i < 8; i++) begin
      evict(i);
      chk(pf_valid == 1'b0, "R2", int'(pf_valid), 0);
    end

    // R3 and R8: fill 4, drop the rest
    for (int i = 0; i < 8; i++) begin
      predict(i, 1);
      chk(pf_valid == 1'b1 && pf_addr == fa(0, 1), "R3", int'(pf_addr), int'(fa(0, 1)));
    end
    // R7 holds while stalled
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(pf_valid == 1'b1 && pf_addr == fa(0, 1), "R7", int'(pf_addr), int'(fa(0, 1)));
    end
    for (int k = 0; k < 4; k++) drain_one(k, 1, "R7");
    chk(pf_valid == 1'b0, "R8", int'(pf_valid), 0);

    // R6 accepted entries are clear; R8 dropped entries still marked
    for (int i = 0; i < 4; i++) begin
      predict(i, 2);
      chk(pf_valid == 1'b0, "R6", int'(pf_valid), 0);
    end
    for (int i = 4; i < 8; i++) predict(i, 2);
    for (int k = 4; k < 8; k++) drain_one(k, 2, "R8");
    chk(pf_valid == 1'b0, "R8", int'(pf_valid), 0);

    // R9 duplicate while waiting
    evict(2);
    predict(2, 3);
    predict(2, 4);
    drain_one(2, 3, "R9");
    chk(pf_valid == 1'b0, "R9", int'(pf_valid), 0);

    // R5 same-cycle eviction and prediction
    evict_valid = 1'b1; evict_idx = 3'd5;
    predict(5, 5);
    evict_valid = 1'b0;
    chk(pf_valid == 1'b0, "R5", int'(pf_valid), 0);
    predict(5, 6);
    drain_one(5, 6, "R5");

    // R6 eviction during accept keeps the mark
    evict(6);
    predict(6, 6);
    chk(pf_valid == 1'b1, "R6", int'(pf_valid), 1);
    evict_valid = 1'b1; evict_idx = 3'd6; pf_ready = 1'b1;
    tick();
    evict_valid = 1'b0; pf_ready = 1'b0;
    chk(pf_valid == 1'b0, "R6", int'(pf_valid), 0);
    predict(6, 7);
    drain_one(6, 7, "R6");
    chk(pf_valid == 1'b0, "R6", int'(pf_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule